// File: doc/BRIEF.md
# Single-Bit NAND ECC Checker and Corrector

This block judges a 512-byte NAND page sector after it has been read. It takes the 24-bit check code that was stored with the sector and the 24-bit code that was calculated while the sector was read back. It XORs the two codes and sorts the difference into one of four outcomes: clean, a single flipped data bit that can be repaired, a fault confined to the stored code, or damage that cannot be repaired. When the outcome is a repairable data bit, it reports the byte offset and the bit position. It then keeps that repair armed, so that sector bytes passed through its buffer port come out with the bad bit inverted.

A separate combinational path converts a raw 32-bit parity accumulator reading into the 24-bit code format. The code keeps accumulator bits 11:0 as its low half and bits 27:16 as its high half, and the whole value is inverted. An erased sector, which reads as all ones, therefore gets a matching code. The code travels as three bytes with the least significant byte first. The parity accumulation itself is done elsewhere.

The buffer port is a single registered valid/ready stage. An input byte is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in that cycle. While `m_valid` is high and `m_ready` is low, the output byte is held unchanged and no input is accepted. Bytes are never dropped or duplicated.

Top module: `ecc1_corrector`

## Requirements
- R1: `packed_code` always equals the bitwise inverse of {raw_acc[27:16], raw_acc[11:0]}, with raw bit 0 landing in code bit 0.
- R2: One cycle after a `cmp_req` whose two codes are equal, `res_status` is 0 (clean).
- R3: When diff = calc XOR stored has low half (bits 11:0) XOR high half (bits 23:12) equal to 0xFFF, and diff[23:15] is below BLOCK_BYTES, `res_status` is 1. In that case `res_offset` = diff[23:15] and `res_bit` = diff[14:12].
- R4: A diff that passes the half-XOR test of R3 but whose offset diff[23:15] is at or above BLOCK_BYTES gives `res_status` 3.
- R5: A diff with exactly one bit set gives `res_status` 2 (the stored code is at fault, the data is good).
- R6: Any other nonzero diff gives `res_status` 3 (uncorrectable). For every status other than 1, `res_offset` and `res_bit` are 0.
- R7: `res_valid` is high for exactly the one cycle after each cycle in which `cmp_req` is high. The result outputs change only in that cycle.
- R8: While the latest result has status 1, a byte accepted on the buffer port with `s_offset` equal to `res_offset` leaves with bit `res_bit` inverted. Every other byte passes through unchanged. A byte accepted in the same cycle that a new result is loaded is judged against the previous result.
- R9: With `m_valid` high and `m_ready` low, `m_valid` stays high, `m_data` stays stable and `s_ready` is low. Each accepted byte appears exactly once on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_acc | input | 32 | Raw parity accumulator value to be packed |
| packed_code | output | 24 | Packed, inverted 24-bit check code |
| cmp_req | input | 1 | Compare request, one cycle per sector |
| stored_code | input | 24 | Check code read back from the spare area |
| calc_code | input | 24 | Check code calculated over the data read |
| res_valid | output | 1 | One-cycle pulse: result outputs are new |
| res_status | output | 2 | 0 clean, 1 data corrected, 2 code-only fault, 3 uncorrectable |
| res_offset | output | 9 | Byte offset of the repairable bit |
| res_bit | output | 3 | Bit position inside that byte |
| s_valid | input | 1 | Buffer port input byte valid |
| s_ready | output | 1 | Buffer port can accept a byte |
| s_offset | input | 9 | Offset of the input byte within the sector |
| s_data | input | 8 | Input byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte, repaired where required |

## Verification
Two functions can fall in the same cycle: loading a new compare result and repairing a byte on the buffer port. The bench first arms a repair at a known offset. It then presents the byte at that offset in the very cycle that a clean compare is requested. That byte must still leave flipped, because the repair in force is the one from before that edge. The same offset sent again afterwards must pass through untouched. Back-pressure is also applied while a repair is armed. The held byte must stay flipped and unchanged until it is drained.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_BAD   = 2'd3
  } ecc_stat_e;
endpackage

// File: rtl/ecc1_pack.sv
module ecc1_pack #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16
) (
  input  logic [RAW_W-1:0]    raw,
  output logic [2*HALF_W-1:0] code
);
  // upper half sits HI_LSB bits up in the accumulator; invert for erased pages
  assign code = ~{raw[HI_LSB+HALF_W-1:HI_LSB], raw[HALF_W-1:0]};
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int BLOCK_BYTES = 512
) (
  input  logic [2*HALF_W-1:0] stored,
  input  logic [2*HALF_W-1:0] calc,
  output ecc_stat_e           status,
  output logic [HALF_W-4:0]   offset,
  output logic [2:0]          bitpos
);
  localparam int OFF_W = HALF_W - 3;
  localparam logic [OFF_W:0] LIMIT = (OFF_W + 1)'(BLOCK_BYTES);

  logic [2*HALF_W-1:0] diff;
  logic [HALF_W-1:0]   fold;
  logic [OFF_W-1:0]    off_f;
  logic                in_range;

  assign diff     = calc ^ stored;
  assign fold     = diff[HALF_W-1:0] ^ diff[2*HALF_W-1:HALF_W];
  assign off_f    = diff[2*HALF_W-1:HALF_W+3];
  assign in_range = {1'b0, off_f} < LIMIT;

  always_comb begin
    status = ST_BAD;
    offset = '0;
    bitpos = '0;
    if (diff == '0) begin
      status = ST_CLEAN;
    end else if (&fold) begin
      if (in_range) begin
        status = ST_FIXED;
        offset = off_f;
        bitpos = diff[HALF_W+2:HALF_W];
      end
    end else if ($onehot(diff)) begin
      status = ST_CODE;
    end
  end
endmodule

// File: rtl/ecc1_fixstage.sv
module ecc1_fixstage #(
  parameter int OFF_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [OFF_W-1:0]          s_offset,
  input  logic [DATA_W-1:0]         s_data,
  input  logic                      fix_en,
  input  logic [OFF_W-1:0]          fix_off,
  input  logic [$clog2(DATA_W)-1:0] fix_bit,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [DATA_W-1:0]         m_data
);
  logic [DATA_W-1:0] mask;
  logic              hit;

  assign hit = fix_en && (s_offset == fix_off);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = hit && (fix_bit == i[$clog2(DATA_W)-1:0]);
  end

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data ^ mask;
    end
  end
endmodule

// File: rtl/ecc1_corrector.sv
module ecc1_corrector
  import ecc1_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int RAW_W       = 32,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RAW_W-1:0]    raw_acc,
  output logic [2*HALF_W-1:0] packed_code,
  input  logic                cmp_req,
  input  logic [2*HALF_W-1:0] stored_code,
  input  logic [2*HALF_W-1:0] calc_code,
  output logic                res_valid,
  output logic [1:0]          res_status,
  output logic [HALF_W-4:0]   res_offset,
  output logic [2:0]          res_bit,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [HALF_W-4:0]   s_offset,
  input  logic [7:0]          s_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [7:0]          m_data
);
  localparam int OFF_W = HALF_W - 3;

  ecc_stat_e        c_status;
  logic [OFF_W-1:0] c_offset;
  logic [2:0]       c_bit;
  ecc_stat_e        r_status;

  ecc1_pack #(.RAW_W(RAW_W), .HALF_W(HALF_W), .HI_LSB(16)) u_pack (
    .raw  (raw_acc),
    .code (packed_code)
  );

  ecc1_classify #(.HALF_W(HALF_W), .BLOCK_BYTES(BLOCK_BYTES)) u_cls (
    .stored (stored_code),
    .calc   (calc_code),
    .status (c_status),
    .offset (c_offset),
    .bitpos (c_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      r_status   <= ST_CLEAN;
      res_offset <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= cmp_req;
      if (cmp_req) begin
        r_status   <= c_status;
        res_offset <= c_offset;
        res_bit    <= c_bit;
      end
    end
  end

  assign res_status = r_status;

  ecc1_fixstage #(.OFF_W(OFF_W), .DATA_W(8)) u_fix (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_offset (s_offset),
    .s_data   (s_data),
    .fix_en   (r_status == ST_FIXED),
    .fix_off  (res_offset),
    .fix_bit  (res_bit),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data)
  );
endmodule

// File: rtl/ecc1_corrector_chk.sv
module ecc1_corrector_chk #(
  parameter int HALF_W      = 12,
  parameter int BLOCK_BYTES = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_req,
  input logic [2*HALF_W-1:0] stored_code,
  input logic [2*HALF_W-1:0] calc_code,
  input logic                res_valid,
  input logic [1:0]          res_status,
  input logic [HALF_W-4:0]   res_offset,
  input logic                s_ready,
  input logic                m_valid,
  input logic                m_ready,
  input logic [7:0]          m_data
);
  // R2
  clean_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && (stored_code == calc_code) |=> res_status == 2'd0);
  // R5
  code_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req && ($countones(stored_code ^ calc_code) == 1) |=> res_status == 2'd2);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> res_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> !res_valid && $stable(res_status) && $stable(res_offset));
  // R3
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status == 2'd1 |-> int'(res_offset) < BLOCK_BYTES);
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  // R9
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
endmodule

bind ecc1_corrector ecc1_corrector_chk #(.HALF_W(HALF_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_req     (cmp_req),
  .stored_code (stored_code),
  .calc_code   (calc_code),
  .res_valid   (res_valid),
  .res_status  (res_status),
  .res_offset  (res_offset),
  .s_ready     (s_ready),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_data      (m_data)
);

// File: tb/ecc1_corrector_tb.sv
module ecc1_corrector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_acc = '0;
  logic [23:0] packed_code;
  logic        cmp_req = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [8:0]  res_offset;
  logic [2:0]  res_bit;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [8:0]  s_offset = '0;
  logic [7:0]  s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;

  logic [23:0] sm_code;
  logic        sm_valid, sm_sready, sm_mvalid;
  logic [1:0]  sm_status;
  logic [8:0]  sm_offset;
  logic [2:0]  sm_bit;
  logic [7:0]  sm_mdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ecc1_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .raw_acc(raw_acc), .packed_code(packed_code),
    .cmp_req(cmp_req), .stored_code(stored_code), .calc_code(calc_code),
    .res_valid(res_valid), .res_status(res_status), .res_offset(res_offset),
    .res_bit(res_bit), .s_valid(s_valid), .s_ready(s_ready), .s_offset(s_offset),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  ecc1_corrector #(.BLOCK_BYTES(256)) u_small (
    .clk(clk), .rst_n(rst_n), .raw_acc(raw_acc), .packed_code(sm_code),
    .cmp_req(cmp_req), .stored_code(stored_code), .calc_code(calc_code),
    .res_valid(sm_valid), .res_status(sm_status), .res_offset(sm_offset),
    .res_bit(sm_bit), .s_valid(1'b0), .s_ready(sm_sready), .s_offset(9'd0),
    .s_data(8'd0), .m_valid(sm_mvalid), .m_ready(1'b1), .m_data(sm_mdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // issue one compare; returns after res_valid should be high
  task automatic compare(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    stored_code = st; calc_code = ca; cmp_req = 1'b1;
    @(negedge clk);
    cmp_req = 1'b0;
  endtask

  task automatic send(input logic [8:0] off, input logic [7:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_offset = off; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  function automatic logic [23:0] fix_diff(input int off, input int b);
    logic [11:0] hi;
    hi = 12'((off << 3) | b);
    return {hi, ~hi};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] base;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R7 reset valid", res_valid, 0);
    check("R2 reset status", res_status, 0);
    check("R9 reset m_valid", m_valid, 0);
    rst_n = 1'b1;

    // R1 pack sweep
    for (int i = 0; i < 64; i++) begin
      r = 32'(i) * 32'h9E3779B9 ^ 32'(i << 20);
      raw_acc = r;
      #1;
      check("R1 pack", packed_code,
            ((r & 32'h0000_0FFF) | ((r & 32'h0FFF_0000) >> 4)) ^ 32'h00FF_FFFF);
    end
    raw_acc = 32'hFFFF_FFFF; #1;
    check("R1 erased", packed_code, 0);

    base = 24'h5A3C96;
    // R2 clean
    compare(base, base);
    check("R7 pulse", res_valid, 1);
    check("R2 clean", res_status, 0);
    @(negedge clk);
    check("R7 single pulse", res_valid, 0);

    // R5 every single-bit diff
    for (int k = 0; k < 24; k++) begin
      compare(base, base ^ (24'd1 << k));
      check("R5 code fault", res_status, 2);
      check("R6 offset zero", res_offset, 0);
    end

    // R3 every offset, varying bit
    for (int o = 0; o < 512; o++) begin
      compare(base, base ^ fix_diff(o, (o * 5) % 8));
      check("R3 status", res_status, 1);
      check("R3 offset", res_offset, o);
      check("R3 bit", res_bit, (o * 5) % 8);
      if (o >= 256) check("R4 small block", sm_status, 3);
      else          check("R3 small block", sm_status, 1);
    end

    // R6 multi-bit diffs not matching the fold rule
    for (int k = 0; k < 23; k++) begin
      compare(base, base ^ (24'd3 << k));
      check("R6 uncorrectable", res_status, 3);
      check("R6 bit zero", res_bit, 0);
    end
    compare(base, ~base);
    check("R6 all flipped", res_status, 3);

    // R8 buffer repair at offset 37 bit 5
    compare(base, base ^ fix_diff(37, 5));
    for (int o = 30; o < 45; o++) begin
      send(9'(o), 8'(o * 3));
      check("R8 data", m_data, 8'(o * 3) ^ ((o == 37) ? 8'h20 : 8'h00));
      check("R9 m_valid", m_valid, 1);
    end

    // R9 back-pressure while repair armed
    @(negedge clk);
    m_ready = 1'b0;
    s_valid = 1'b1; s_offset = 9'd37; s_data = 8'h0F;
    @(negedge clk);
    check("R8 held flip", m_data, 8'h2F);
    check("R9 stall ready", s_ready, 0);
    s_offset = 9'd38; s_data = 8'hAA;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold data", m_data, 8'h2F);
    check("R9 hold valid", m_valid, 1);
    m_ready = 1'b1;
    @(negedge clk);
    check("R9 next byte", m_data, 8'hAA);
    s_valid = 1'b0;
    @(negedge clk);
    check("R9 drained", m_valid, 0);

    // R8 same-cycle: clean compare and byte at armed offset together
    @(negedge clk);
    stored_code = base; calc_code = base; cmp_req = 1'b1;
    s_valid = 1'b1; s_offset = 9'd37; s_data = 8'h00;
    @(negedge clk);
    cmp_req = 1'b0;
    check("R8 same-cycle old repair", m_data, 8'h20);
    check("R2 same-cycle status", res_status, 0);
    s_data = 8'h00;
    @(negedge clk);
    s_valid = 1'b0;
    check("R8 repair disarmed", m_data, 8'h00);

    // R8 no repair after code-only fault
    compare(base, base ^ 24'h000100);
    send(9'd37, 8'h11);
    check("R8 no flip status2", m_data, 8'h11);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule